// File: doc/BRIEF.md
# Manchester Line Receiver with Preamble Lock

This block takes a single Manchester-coded serial line, which carries clock and data together as their XOR, and turns it back into bytes. The line is sampled by a system clock running a fixed whole multiple (eight or more) of the bit rate. A transition in the middle of each bit cell carries the value: rising means 1, falling means 0. Transitions at the cell boundaries only set the line up for the next mid-cell edge and are discarded by a timing window.

After reset, or after the line goes quiet, the receiver hunts for the training pattern. This is a run of alternating bits, which looks like a square wave at the bit rate and lets the edge timer lock. The run must end in two consecutive ones, which mark the start of the frame. From then on, bits are packed into bytes with the least significant bit first, and each byte comes out with a one-cycle strobe. When no mid-cell edge arrives for more than two bit times, the frame is closed with a one-cycle end pulse. If fewer than the minimum number of whole bytes arrived, a runt flag comes with that pulse. The receiver then returns to hunting.

Top module: `manch_rx`

## Requirements
- R1: A rising edge in the middle of a bit cell decodes as 1, and a falling edge decodes as 0.
- R2: An edge that arrives fewer than (3*OVS)/4 clock cycles after the last accepted mid-cell edge is a boundary edge and produces no bit. With OVS=8, boundary edges 4 cycles after a mid-cell edge are rejected.
- R3: `frame_active` rises only after at least ALT_MIN (default 16) alternating bits followed by two consecutive 1 bits. No bit received before that point is ever output as data.
- R4: Frame bits are packed with the least significant bit first, so the first bit after the start pattern becomes bit 0 of the first byte. Each complete byte is presented on `byte_data` with `byte_valid` high for exactly one cycle.
- R5: If no edge is accepted for 2*OVS+1 cycles during a frame, `frame_end` pulses for one cycle and `frame_active` falls. An edge arriving exactly 2*OVS cycles after the last accepted edge is taken as a bit and does not end the frame.
- R6: `frame_runt` is high in the cycle of `frame_end` exactly when fewer than MIN_BYTES (default 64) complete bytes were delivered in that frame. Trailing bits that do not fill a byte are discarded.
- R7: During and immediately after reset, `byte_valid`, `frame_end`, `frame_runt` and `frame_active` are all 0.
- R8: A quiet line while hunting, including after a rejected short training pattern, produces no `frame_end` and no bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, OVS cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Manchester-coded serial line, idles low |
| byte_data | output | 8 | Most recently completed byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| frame_active | output | 1 | High between start pattern and end of frame |
| frame_end | output | 1 | One-cycle pulse when the line goes quiet in a frame |
| frame_runt | output | 1 | Valid with `frame_end`: frame had too few bytes |

## Verification
The edge timer can see an incoming edge in the same cycle that its gap count reaches the idle limit. In that collision the edge must win: it yields a bit, and the frame stays open. The bench provokes this by holding the line after a byte and then toggling it exactly 2*OVS cycles after the last mid-cell edge. It then checks that no frame end appears soon after the toggle. It repeats the test with the toggle one cycle later and expects the frame to have already closed, with the toggle arriving in the hunt state and giving no output.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic stb;
        logic val;
    } bit_ev_t;

    localparam int BYTE_W = 8;

    // Start-of-frame pair: two ones back to back after the training run
    function automatic logic sof_pair(input logic prev_bit, input logic cur_bit);
        return prev_bit & cur_bit;
    endfunction

endpackage

// File: rtl/mrx_line_edge.sv
module mrx_line_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic edge_o,
    output logic level_o
);
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], line_in};
    end

    assign level_o = chain[SYNC_STAGES-1];
    assign edge_o  = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
endmodule

// File: rtl/mrx_bit_clock.sv
module mrx_bit_clock
    import mrx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    edge_i,
    input  logic    level_i,
    output bit_ev_t bit_o,
    output logic    idle_o
);
    localparam int ACCEPT   = (3 * OVS) / 4;
    localparam int IDLE_LIM = 2 * OVS;
    localparam int SAT      = IDLE_LIM + 1;
    localparam int CW       = $clog2(SAT + 1);

    // Cycles since last accepted mid-cell edge; SAT means unlocked
    logic [CW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= CW'(SAT);
            bit_o  <= '0;
            idle_o <= 1'b0;
        end else begin
            bit_o.stb <= 1'b0;
            idle_o    <= 1'b0;
            if (edge_i && gap >= CW'(ACCEPT)) begin
                gap       <= CW'(1);
                bit_o.stb <= 1'b1;
                bit_o.val <= level_i;
            end else if (gap == CW'(IDLE_LIM)) begin
                gap    <= CW'(SAT);
                idle_o <= 1'b1;
            end else if (gap != CW'(SAT)) begin
                gap <= gap + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mrx_framer.sv
module mrx_framer
    import mrx_pkg::*;
#(
    parameter int ALT_MIN   = 16,
    parameter int MIN_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_ev_t           bit_i,
    input  logic              idle_i,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              frame_active,
    output logic              frame_end,
    output logic              frame_runt
);
    localparam int AW = $clog2(ALT_MIN + 1);
    localparam int BW = $clog2(MIN_BYTES + 1);
    localparam int PW = $clog2(BYTE_W);

    rx_state_e         state;
    logic [AW-1:0]     alt_cnt;
    logic              prev_bit;
    logic [BYTE_W-1:0] shreg;
    logic [PW-1:0]     bit_pos;
    logic [BW-1:0]     byte_cnt;
    logic [BYTE_W-1:0] next_byte;

    assign next_byte    = {bit_i.val, shreg[BYTE_W-1:1]};
    assign frame_active = (state == ST_FRAME);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HUNT;
            alt_cnt    <= '0;
            prev_bit   <= 1'b0;
            shreg      <= '0;
            bit_pos    <= '0;
            byte_cnt   <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
            frame_end  <= 1'b0;
            frame_runt <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            frame_end  <= 1'b0;
            frame_runt <= 1'b0;
            unique case (state)
                ST_HUNT: begin
                    if (idle_i) begin
                        alt_cnt <= '0;
                    end else if (bit_i.stb) begin
                        prev_bit <= bit_i.val;
                        if (alt_cnt == '0) begin
                            alt_cnt <= AW'(1);
                        end else if (bit_i.val != prev_bit) begin
                            if (alt_cnt != AW'(ALT_MIN)) alt_cnt <= alt_cnt + 1'b1;
                        end else if (sof_pair(prev_bit, bit_i.val) &&
                                     alt_cnt >= AW'(ALT_MIN)) begin
                            state    <= ST_FRAME;
                            alt_cnt  <= '0;
                            bit_pos  <= '0;
                            byte_cnt <= '0;
                        end else begin
                            alt_cnt <= AW'(1);
                        end
                    end
                end
                ST_FRAME: begin
                    if (idle_i) begin
                        state      <= ST_HUNT;
                        frame_end  <= 1'b1;
                        frame_runt <= (byte_cnt < BW'(MIN_BYTES));
                    end else if (bit_i.stb) begin
                        shreg   <= next_byte;
                        bit_pos <= bit_pos + 1'b1;
                        if (bit_pos == PW'(BYTE_W - 1)) begin
                            byte_data  <= next_byte;
                            byte_valid <= 1'b1;
                            if (byte_cnt != BW'(MIN_BYTES)) byte_cnt <= byte_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/manch_rx.sv
module manch_rx
    import mrx_pkg::*;
#(
    parameter int OVS         = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ALT_MIN     = 16,
    parameter int MIN_BYTES   = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    output logic       frame_active,
    output logic       frame_end,
    output logic       frame_runt
);
    logic    edge_s;
    logic    level_s;
    bit_ev_t bit_s;
    logic    idle_s;

    mrx_line_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .edge_o  (edge_s),
        .level_o (level_s)
    );

    mrx_bit_clock #(.OVS(OVS)) u_clock (
        .clk     (clk),
        .rst     (rst),
        .edge_i  (edge_s),
        .level_i (level_s),
        .bit_o   (bit_s),
        .idle_o  (idle_s)
    );

    mrx_framer #(.ALT_MIN(ALT_MIN), .MIN_BYTES(MIN_BYTES)) u_framer (
        .clk          (clk),
        .rst          (rst),
        .bit_i        (bit_s),
        .idle_i       (idle_s),
        .byte_data    (byte_data),
        .byte_valid   (byte_valid),
        .frame_active (frame_active),
        .frame_end    (frame_end),
        .frame_runt   (frame_runt)
    );
endmodule

// File: rtl/manch_rx_chk.sv
module manch_rx_chk (
    input logic clk,
    input logic rst,
    input logic byte_valid,
    input logic frame_active,
    input logic frame_end,
    input logic frame_runt
);
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    assert_byte_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> frame_active);

    assert_end_closes_frame_R5: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> ($past(frame_active) && !frame_active));

    assert_end_single_R5: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

    assert_runt_with_end_R6: assert property (@(posedge clk) disable iff (rst)
        frame_runt |-> frame_end);

    assert_hunt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_active) |-> !frame_end);

    assert_no_clash_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byte_valid, frame_end}));
endmodule

bind manch_rx manch_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_valid   (byte_valid),
    .frame_active (frame_active),
    .frame_end    (frame_end),
    .frame_runt   (frame_runt)
);

// File: tb/manch_rx_bench.sv
module manch_rx_bench;
    localparam int OVS       = 8;
    localparam int HALF      = OVS / 2;
    localparam int MIN_BYTES = 64;
    localparam int NVEC      = 5;
    // Frame length per vector; expected runt is derived from it
    localparam int FRAME_LEN [NVEC] = '{3, 63, 64, 1, 70};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_in = 1'b0;
    logic [7:0] byte_data;
    logic       byte_valid, frame_active, frame_end, frame_runt;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rx_bytes [0:1023];
    int   rx_n   = 0;
    int   end_n  = 0;
    logic last_runt = 1'b0;

    always #5 clk = ~clk;

    manch_rx u_manch_rx (
        .clk(clk), .rst(rst), .line_in(line_in),
        .byte_data(byte_data), .byte_valid(byte_valid),
        .frame_active(frame_active), .frame_end(frame_end), .frame_runt(frame_runt)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                rx_bytes[rx_n] <= byte_data;
                rx_n <= rx_n + 1;
            end
            if (frame_end) begin
                end_n     <= end_n + 1;
                last_runt <= frame_runt;
            end
        end
    end

    function automatic logic [7:0] pay(input int f, input int k);
        return 8'((k * 37 + f * 11 + 5) % 256);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Manchester cell: 1 = low then high, 0 = high then low
    task automatic send_bit(input logic b);
        line_in = ~b;
        repeat (HALF) @(negedge clk);
        line_in = b;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_pre(input int alt_bits);
        for (int j = 0; j < alt_bits; j++) send_bit((j % 2) == 0);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int j = 0; j < 8; j++) send_bit(v[j]);
    endtask

    task automatic quiet();
        repeat (40) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int base;
        int bad;
        int ends0;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 byte_valid", byte_valid, 0);
        chk("R7 frame_end", frame_end, 0);
        chk("R7 frame_active", frame_active, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 runt after reset", frame_runt, 0);
        chk("R7 active after reset", frame_active, 0);

        // Table-driven frames: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            base  = rx_n;
            ends0 = end_n;
            send_pre(62);
            for (int k = 0; k < FRAME_LEN[v]; k++) send_byte(pay(v, k));
            #1;
            chk("R3 active during frame", frame_active, 1);
            quiet();
            chk("R4 byte count", rx_n - base, FRAME_LEN[v]);
            bad = 0;
            for (int k = 0; k < FRAME_LEN[v]; k++)
                if (rx_bytes[base + k] !== pay(v, k)) bad++;
            chk("R1 R2 R4 byte values mismatches", bad, 0);
            chk("R5 one frame end", end_n - ends0, 1);
            chk("R6 runt flag", last_runt, (FRAME_LEN[v] < MIN_BYTES) ? 1 : 0);
            chk("R5 back to hunt", frame_active, 0);
        end

        // R3 R8: short training run then 11 must not open a frame
        base  = rx_n;
        ends0 = end_n;
        send_pre(8);
        send_byte(8'h00);
        send_byte(8'hFF);
        quiet();
        chk("R3 short preamble no bytes", rx_n - base, 0);
        chk("R8 no end in hunt", end_n - ends0, 0);

        // R6: trailing partial byte discarded
        base  = rx_n;
        send_pre(62);
        send_byte(8'hA5);
        send_byte(8'h3C);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        quiet();
        chk("R6 partial bytes count", rx_n - base, 2);
        chk("R6 partial byte0", rx_bytes[base], 8'hA5);
        chk("R6 partial runt", last_runt, 1);

        // R5 collision: edge exactly 2*OVS after last mid edge wins
        ends0 = end_n;
        send_pre(62);
        send_byte(8'h81);
        repeat (2 * OVS - HALF) @(negedge clk);
        line_in = ~line_in;
        repeat (6) @(negedge clk);
        #1;
        chk("R5 edge at limit keeps frame", end_n - ends0, 0);
        chk("R5 still active", frame_active, 1);
        quiet();
        chk("R5 closed later", end_n - ends0, 1);

        // R5: one cycle later, frame already closed
        ends0 = end_n;
        base  = rx_n;
        send_pre(62);
        send_byte(8'h42);
        repeat (2 * OVS - HALF + 1) @(negedge clk);
        line_in = ~line_in;
        repeat (6) @(negedge clk);
        #1;
        chk("R5 gap over limit ends frame", end_n - ends0, 1);
        chk("R5 inactive after gap", frame_active, 0);
        quiet();
        chk("R8 stray edge in hunt", end_n - ends0, 1);
        chk("R4 single byte kept", rx_n - base, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule